// File: doc/BRIEF.md
# Hall Commutation Decoder with Direction

This block turns three digitized Hall sensor levels into the six gate-drive enables of a three-phase bipolar motor bridge. There are three high-side enables and three low-side enables, one pair of each per phase. A direction input chooses forward or reverse rotation. Reverse rotation reuses the forward decode on the bitwise complement of the Hall code. A code in which all three sensors agree is not a legal rotor position, so it drives every output low.

The high-side enables are the switched side. A modulator supplies a PWM enable that gates them, and an under-voltage trip or a stall trip forces them off. The low-side enables stay on for the whole commutation step. The Hall levels and the direction input each pass through a two-flop synchronizer. When the synchronized direction changes, every output is held low for a dead time counted in clock cycles, and only then is the new pattern applied. This prevents both switches of one phase from conducting at the same moment during a reversal.

Top module: `hall_commutator`

## Requirements
- R1: With direction forward (`dir_rev`=0), each Hall code `hall_in`={IN1,IN2,IN3} (IN1 is bit 2) selects one high-side and one low-side output. Phase bits in both drive vectors are U=bit0, V=bit1, W=bit2. The six codes map as follows: 101 gives V-high with U-low, 100 gives W-high with U-low, 110 gives W-high with V-low, 010 gives U-high with V-low, 011 gives U-high with W-low, and 001 gives V-high with W-low.
- R2: With direction reverse (`dir_rev`=1), the same six output pairs in the R1 order are selected by the codes 010, 011, 001, 101, 100, 110.
- R3: Hall codes 000 and 111 drive all six outputs low in either direction.
- R4: While `pwm_on` is 0, all high-side outputs are 0. The low-side outputs keep the pattern of R1/R2.
- R5: While `uv_trip` or `stall_trip` is 1, all high-side outputs are 0. The low-side outputs are unaffected.
- R6: A change on `hall_in` appears at the outputs after the third rising clock edge: two synchronizer stages and one output register. The previous pattern is still present after the second edge.
- R7: A change on `dir_rev` drives all outputs low from the third rising edge for DEAD_CYC+1 clock cycles. The pattern for the new direction appears after edge DEAD_CYC+4. The previous pattern is still present after the second edge.
- R8: At any time, at most one high-side and at most one low-side output is active, and the two are never on the same phase.
- R9: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 3 | Hall levels {IN1,IN2,IN3}, unsynchronized |
| dir_rev | input | 1 | 0 = forward, 1 = reverse |
| pwm_on | input | 1 | PWM enable for the high side |
| uv_trip | input | 1 | Under-voltage trip, forces the high side off |
| stall_trip | input | 1 | Stall protection off-phase, forces the high side off |
| hs_drive | output | 3 | High-side enables {W,V,U} |
| ls_drive | output | 3 | Low-side enables {W,V,U} |

## Verification
A wrong decode entry shows up as a wrong or overlapping phase pair. It is visible three edges after the offending Hall code is applied, so every code is walked in both directions and both the stale and the fresh pattern are sampled. A dead-time counter that stops early or late moves the edge on which the new direction's pattern appears. A stale applied direction shows the old direction's pair after the window. Either fault is visible within DEAD_CYC+4 cycles of the reversal. Gating faults appear immediately at the high-side pins while the low side stays lit.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

  typedef struct packed {
    logic [2:0] hi;  // {W,V,U}
    logic [2:0] lo;  // {W,V,U}
  } drive_t;

  localparam logic [2:0] PH_U = 3'b001;
  localparam logic [2:0] PH_V = 3'b010;
  localparam logic [2:0] PH_W = 3'b100;

  // Forward decode of one sensor code; illegal codes give no drive.
  function automatic drive_t fwd_step(input logic [2:0] code);
    drive_t d;
    d = '0;
    case (code)
      3'b101:  begin d.hi = PH_V; d.lo = PH_U; end
      3'b100:  begin d.hi = PH_W; d.lo = PH_U; end
      3'b110:  begin d.hi = PH_W; d.lo = PH_V; end
      3'b010:  begin d.hi = PH_U; d.lo = PH_V; end
      3'b011:  begin d.hi = PH_U; d.lo = PH_W; end
      3'b001:  begin d.hi = PH_V; d.lo = PH_W; end
      default: d = '0;
    endcase
    return d;
  endfunction

  // Reverse rotation reuses the forward decode on the complemented code.
  function automatic drive_t commutate(input logic [2:0] code, input logic rev);
    return fwd_step(rev ? ~code : code);
  endfunction

  function automatic logic code_illegal(input logic [2:0] code);
    return (code == 3'b000) || (code == 3'b111);
  endfunction

endpackage

// File: rtl/hcd_sync.sv
module hcd_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/hcd_dead_guard.sv
module hcd_dead_guard #(
  parameter int DEAD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_in,
  output logic dir_eff,
  output logic blank
);
  localparam int CW = $clog2(DEAD_CYC + 1);

  logic          dir_q;
  logic [CW-1:0] cnt_q;
  logic          dir_flip;

  assign dir_flip = (dir_in != dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      cnt_q <= '0;
    end else if (dir_flip) begin
      dir_q <= dir_in;
      cnt_q <= CW'(DEAD_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dir_eff = dir_q;
  assign blank   = dir_flip || (cnt_q != '0);

  // R7: the window restarts on a flip and then counts down by one per cycle
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_flip && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r7_flip_loads: assert property (@(posedge clk) disable iff (!rst_n)
    dir_flip |=> (cnt_q == CW'(DEAD_CYC)) && (dir_q == $past(dir_in)));
endmodule

// File: rtl/hcd_decode.sv
module hcd_decode
  import hcd_pkg::*;
(
  input  logic [2:0] code,
  input  logic       rev,
  output drive_t     step
);
  always_comb step = commutate(code, rev);
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hcd_pkg::*;
#(
  parameter int DEAD_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_in,
  input  logic       dir_rev,
  input  logic       pwm_on,
  input  logic       uv_trip,
  input  logic       stall_trip,
  output logic [2:0] hs_drive,
  output logic [2:0] ls_drive
);
  logic [2:0] hall_s;
  logic       dir_s;
  logic       dir_eff;
  logic       blank;
  logic       hs_enable;
  drive_t     step;
  drive_t     pattern_q;

  hcd_sync #(.W(4), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({dir_rev, hall_in}),
    .d_sync  ({dir_s, hall_s})
  );

  hcd_dead_guard #(.DEAD_CYC(DEAD_CYC)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_in  (dir_s),
    .dir_eff (dir_eff),
    .blank   (blank)
  );

  hcd_decode u_dec (
    .code (hall_s),
    .rev  (dir_eff),
    .step (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pattern_q <= '0;
    else if (blank) pattern_q <= '0;
    else            pattern_q <= step;
  end

  assign hs_enable = pwm_on && !uv_trip && !stall_trip;
  assign hs_drive  = pattern_q.hi & {3{hs_enable}};
  assign ls_drive  = pattern_q.lo;

  // R8: one pair at most, on different phases, equal in count
  a_r8_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pattern_q.hi) && $onehot0(pattern_q.lo) &&
    ($countones(pattern_q.hi) == $countones(pattern_q.lo)));
  a_r8_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_drive & ls_drive) == 3'b000);
  // R3: an illegal sensor code leaves nothing on
  a_r3_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
    code_illegal(hall_s) |=> (pattern_q == '0));
  // R4: no PWM enable, no high side
  a_r4_pwm_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_on |-> (hs_drive == 3'b000));
  // R5: protection trips silence the high side only
  a_r5_prot_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_trip || stall_trip) |-> (hs_drive == 3'b000) && (ls_drive == pattern_q.lo));
  // R7: the dead window keeps the bridge off, including the switch edge
  a_r7_dead_blank: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (pattern_q == '0));
  a_r7_switch_off: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_eff != $past(dir_eff)) |-> (pattern_q == '0));
endmodule

// File: tb/tb_hall_commutator.sv
`timescale 1ns/1ps
module tb_hall_commutator;
  localparam int DEAD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall_in = 3'b000;
  logic       dir_rev = 1'b0;
  logic       pwm_on = 1'b1;
  logic       uv_trip = 1'b0;
  logic       stall_trip = 1'b0;
  logic [2:0] hs_drive, ls_drive;

  int n_run  = 0;
  int n_fail = 0;

  typedef struct {
    logic [2:0] hs;
    logic [2:0] ls;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  hall_commutator #(.DEAD_CYC(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_rev(dir_rev),
    .pwm_on(pwm_on), .uv_trip(uv_trip), .stall_trip(stall_trip),
    .hs_drive(hs_drive), .ls_drive(ls_drive)
  );

  // Expected pair {hs,ls} restated from the R1/R2 tables
  function automatic logic [5:0] model(input logic [2:0] h, input logic rev);
    case ({rev, h})
      4'b0_101, 4'b1_010: return {3'b010, 3'b001};
      4'b0_100, 4'b1_011: return {3'b100, 3'b001};
      4'b0_110, 4'b1_001: return {3'b100, 3'b010};
      4'b0_010, 4'b1_101: return {3'b001, 3'b010};
      4'b0_011, 4'b1_100: return {3'b001, 3'b100};
      4'b0_001, 4'b1_110: return {3'b010, 3'b100};
      default:            return 6'b000000;
    endcase
  endfunction

  task automatic expect_after(input int edges, input logic [5:0] p, input string tag);
    repeat (edges) @(posedge clk);
    #1;
    sb.push_back('{hs: p[5:3], ls: p[2:0], tag: tag});
  endtask

  task automatic set_in(input logic [2:0] h, input logic d, input logic p,
                        input logic u, input logic s);
    @(negedge clk);
    hall_in = h; dir_rev = d; pwm_on = p; uv_trip = u; stall_trip = s;
  endtask

  // Monitor: compares queued expectations after each edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_run++;
        if (hs_drive !== e.hs || ls_drive !== e.ls) begin
          n_fail++;
          $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b",
                   e.tag, hs_drive, ls_drive, e.hs, e.ls);
        end
        n_run++;
        if ((hs_drive & ls_drive) !== 3'b000) begin
          n_fail++;
          $display("FAIL R8: overlap hs=%b ls=%b expected no shared phase",
                   hs_drive, ls_drive);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] prev;
    // R9: reset state, even with a legal code applied
    hall_in = 3'b101;
    repeat (4) @(posedge clk);
    #1;
    sb.push_back('{hs: 3'b000, ls: 3'b000, tag: "R9 reset"});
    @(negedge clk);
    rst_n = 1'b1;
    hall_in = 3'b000;
    repeat (4) @(posedge clk);

    // R1/R3/R6: forward walk over every code
    prev = 6'b000000;
    for (int c = 0; c < 8; c++) begin
      set_in(3'(c), 1'b0, 1'b1, 1'b0, 1'b0);
      expect_after(2, prev, "R6 stale after 2nd edge");
      expect_after(1, model(3'(c), 1'b0), (c == 0 || c == 7) ? "R3 fwd" : "R1 fwd");
      prev = model(3'(c), 1'b0);
    end

    // R7: reversal from a settled forward step
    set_in(3'b101, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_after(4, model(3'b101, 1'b0), "R1 settle");
    set_in(3'b101, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_after(2, model(3'b101, 1'b0), "R7 old pattern before window");
    expect_after(1, 6'b000000, "R7 window start");
    for (int k = 0; k < DEAD; k++) expect_after(1, 6'b000000, "R7 window hold");
    expect_after(1, model(3'b101, 1'b1), "R7 new direction applied");

    // R2/R3/R6: reverse walk over every code
    prev = model(3'b101, 1'b1);
    for (int c = 0; c < 8; c++) begin
      set_in(3'(c), 1'b1, 1'b1, 1'b0, 1'b0);
      expect_after(2, prev, "R6 stale after 2nd edge");
      expect_after(1, model(3'(c), 1'b1), (c == 0 || c == 7) ? "R3 rev" : "R2 rev");
      prev = model(3'(c), 1'b1);
    end

    // R4/R5: high-side gating, low side untouched
    set_in(3'b010, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_after(4, {3'b010, 3'b001}, "R2 gate base");
    set_in(3'b010, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_after(1, {3'b000, 3'b001}, "R4 pwm off");
    set_in(3'b010, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_after(1, {3'b000, 3'b001}, "R5 undervoltage");
    set_in(3'b010, 1'b1, 1'b1, 1'b0, 1'b1);
    expect_after(1, {3'b000, 3'b001}, "R5 stall");
    set_in(3'b010, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_after(1, {3'b010, 3'b001}, "R4 pwm back on");

    repeat (3) @(posedge clk);
    #5;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule